// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter. It drives a 3-bit channel select toward an external analog multiplexer, an enable toward an external sample/hold, and an 8-bit trial code toward an external DAC. It reads one comparator bit per decision and builds the result from the most significant bit downward. Each finished result goes into a data register, and an end-of-conversion flag is raised with it.

Software controls the block through a two-address register port. Address 0 is the control register and address 1 is the read-only result. A conversion starts when software sets the run bit. It can also start on a falling edge of an external trigger pin when triggering is enabled. Single mode converts once and then clears the run bit. Continuous mode restarts with no gap. Clearing the run bit aborts a conversion in progress. Power-down holds the sequencer in a quiet state.

The sequencer has five states: `ST_IDLE`, `ST_SAMPLE`, `ST_DECIDE`, `ST_SETTLE` and `ST_PDOWN`. Its transitions are:
- Start: `ST_IDLE` → `ST_SAMPLE` when run is set.
- Sample end: `ST_SAMPLE` → `ST_DECIDE` when the sample budget expires.
- Last decision: `ST_DECIDE` → `ST_SETTLE` after the eighth bit slot.
- Finish: `ST_SETTLE` → `ST_IDLE` in single mode, or `ST_SETTLE` → `ST_SAMPLE` in continuous mode.
- Abort: any active state → `ST_IDLE` when run is cleared.
- Sleep: any state → `ST_PDOWN` while the power-down bit is set.
- Wake: `ST_PDOWN` → `ST_IDLE` when the power-down bit is cleared.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, both registers read 0, `eoc` and `sample_en` are low, `analog_en` is high and `chan_sel` is 0.
- R2: The comparator input means "analog input ≥ trial code". The trial code starts at 0x80 and is decided one bit at a time from the MSB down. The stored result equals the 8-bit input level.
- R3: In slow mode (control bit 3 = 0), the first conversion enters sampling one cycle after the run bit is written. Conversion takes 138 cycles, so `eoc` rises 139 clock edges after the write edge.
- R4: In fast mode (control bit 3 = 1), conversion takes 78 cycles, so `eoc` rises 79 edges after the write edge.
- R5: `sample_en` is high for exactly 84 cycles (slow) or 48 cycles (fast) per conversion, and `dac_code` is 0 while it is high.
- R6: In single mode (control bit 4 = 0), the run bit (control bit 5) reads 0 after the result is stored, and no further conversion follows.
- R7: In continuous mode (control bit 4 = 1), conversions follow back to back, with results every 138 (slow) or 78 (fast) cycles.
- R8: A falling edge on `ext_trig_n` starts a conversion only when trigger enable (control bit 6) is 1. Otherwise the edge has no effect.
- R9: Writing the run bit to 0 mid-conversion returns the block to idle. No `eoc` is raised and the data register is unchanged.
- R10: While power-down (control bit 7) is 1, `sample_en` and `analog_en` are low and neither run writes nor triggers start a conversion.
- R11: Reading address 1 returns the result and clears `eoc`. The data register changes only when `eoc` is raised.
- R12: Control bits [2:0] drive `chan_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flag on address 1) |
| addr | input | 1 | 0 = control, 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| ext_trig_n | input | 1 | External start trigger, falling-edge active, asynchronous |
| cmp_in | input | 1 | Comparator result, 1 when input ≥ trial code |
| chan_sel | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | Sample/hold tracking enable |
| analog_en | output | 1 | Analog section enable, low in power-down |
| dac_code | output | 8 | Trial code to the DAC |
| eoc | output | 1 | End-of-conversion flag |

## Verification
The hardest cases to reach from the ports are an abort landing in the middle of the bit decisions and a continuous run that restarts on the same edge the previous result is stored. The bench reaches the first by writing the run bit low a fixed number of cycles after a slow start. It then watches that `eoc` and the data register stay unchanged. For the second, it clears the flag by reading the result and counts edges to the next `eoc`. A sweep of all 256 input levels, rotating across all eight channels, drives an arithmetic comparator model and exercises every decision path.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int RES   = 8;
    localparam int NCH   = 8;
    localparam int CH_W  = $clog2(NCH);
    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_DECIDE,
        ST_SETTLE,
        ST_PDOWN
    } seq_state_t;

    // Control register layout, MSB first
    typedef struct packed {
        logic            pdown;
        logic            trig_en;
        logic            run;
        logic            cont;
        logic            fast;
        logic [CH_W-1:0] chan;
    } ctrl_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fell
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], pin_n};
        end
    end

    // sync_q[1] is the second synchroniser stage, sync_q[2] its delayed copy
    assign fell = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int RW = RES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             trig_fell,
    input  logic             done,
    input  logic [RW-1:0]    result,
    output ctrl_t            ctrl,
    output logic [RW-1:0]    data_q,
    output logic             eoc_q
);
    ctrl_t ctrl_q;
    ctrl_t wr_val;

    always_comb begin
        wr_val = ctrl_t'(wdata);
        if (wr_val.pdown) begin
            wr_val.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
            eoc_q  <= 1'b0;
        end else begin
            if (rd_en && addr == ADDR_DATA) begin
                eoc_q <= 1'b0;
            end
            if (done) begin
                data_q <= result;
                eoc_q  <= 1'b1;
                if (!ctrl_q.cont) begin
                    ctrl_q.run <= 1'b0;
                end
            end
            if (trig_fell && ctrl_q.trig_en && !ctrl_q.pdown) begin
                ctrl_q.run <= 1'b1;
            end
            if (wr_en && addr == ADDR_CTRL) begin
                ctrl_q <= wr_val;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata = BUS_W'(ctrl_q);
        end else begin
            rdata[RW-1:0] = data_q;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RW         = RES,
    parameter int SAMP_SLOW  = 84,
    parameter int SAMP_FAST  = 48,
    parameter int SLOT_SLOW  = 6,
    parameter int SLOT_FAST  = 3,
    parameter int SETTLE_CYC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          fast,
    input  logic          cont,
    input  logic          pdown,
    input  logic          cmp_in,
    output seq_state_t    state,
    output logic          sample_en,
    output logic          analog_en,
    output logic [RW-1:0] dac_code,
    output logic          done,
    output logic [RW-1:0] result
);
    localparam int MAXC  = (SAMP_SLOW > SAMP_FAST) ? SAMP_SLOW : SAMP_FAST;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int IDX_W = $clog2(RW);
    localparam logic [CNT_W-1:0] SAMP_S_LAST = CNT_W'(SAMP_SLOW - 1);
    localparam logic [CNT_W-1:0] SAMP_F_LAST = CNT_W'(SAMP_FAST - 1);
    localparam logic [CNT_W-1:0] SLOT_S_LAST = CNT_W'(SLOT_SLOW - 1);
    localparam logic [CNT_W-1:0] SLOT_F_LAST = CNT_W'(SLOT_FAST - 1);
    localparam logic [CNT_W-1:0] SETL_LAST   = CNT_W'(SETTLE_CYC - 1);
    localparam logic [IDX_W-1:0] TOP_IDX     = IDX_W'(RW - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [RW-1:0]    sar_q, sar_d;
    logic             fast_q, fast_d;
    logic [CNT_W-1:0] samp_last, slot_last;

    assign samp_last = fast_q ? SAMP_F_LAST : SAMP_S_LAST;
    assign slot_last = fast_q ? SLOT_F_LAST : SLOT_S_LAST;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sar_q   <= '0;
            fast_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sar_q   <= sar_d;
            fast_q  <= fast_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sar_d   = sar_q;
        fast_d  = fast_q;
        unique case (state_q)
            ST_PDOWN: begin
                if (!pdown) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_SAMPLE;
                    cnt_d   = '0;
                    fast_d  = fast;
                    sar_d   = '0;
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == samp_last) begin
                    state_d        = ST_DECIDE;
                    cnt_d          = '0;
                    sar_d          = '0;
                    sar_d[TOP_IDX] = 1'b1;
                    idx_d          = TOP_IDX;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DECIDE: begin
                if (cnt_q == slot_last) begin
                    cnt_d = '0;
                    if (!cmp_in) begin
                        sar_d[idx_q] = 1'b0;
                    end
                    if (idx_q == '0) begin
                        state_d = ST_SETTLE;
                    end else begin
                        sar_d[idx_q - 1'b1] = 1'b1;
                        idx_d               = idx_q - 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == SETL_LAST) begin
                    cnt_d = '0;
                    if (cont) begin
                        state_d = ST_SAMPLE;
                        fast_d  = fast;
                        sar_d   = '0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (pdown) begin
            state_d = ST_PDOWN;
        end else if (!run && (state_q == ST_SAMPLE || state_q == ST_DECIDE
                              || state_q == ST_SETTLE)) begin
            state_d = ST_IDLE;
        end
    end

    // outputs
    always_comb begin
        sample_en = (state_q == ST_SAMPLE);
        analog_en = (state_q != ST_PDOWN);
        dac_code  = sar_q;
        result    = sar_q;
        done      = (state_q == ST_SETTLE) && (cnt_q == SETL_LAST) && run && !pdown;
    end

    assign state = state_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             ext_trig_n,
    input  logic             cmp_in,
    output logic [CH_W-1:0]  chan_sel,
    output logic             sample_en,
    output logic             analog_en,
    output logic [RES-1:0]   dac_code,
    output logic             eoc
);
    ctrl_t          ctrl;
    logic           trig_fell;
    logic           done;
    logic [RES-1:0] result;
    logic [RES-1:0] data_q;
    seq_state_t     state;

    adc_seq_trig u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_trig_n),
        .fell  (trig_fell)
    );

    adc_seq_regs #(.RW(RES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .trig_fell (trig_fell),
        .done      (done),
        .result    (result),
        .ctrl      (ctrl),
        .data_q    (data_q),
        .eoc_q     (eoc)
    );

    adc_seq_fsm #(.RW(RES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.run),
        .fast      (ctrl.fast),
        .cont      (ctrl.cont),
        .pdown     (ctrl.pdown),
        .cmp_in    (cmp_in),
        .state     (state),
        .sample_en (sample_en),
        .analog_en (analog_en),
        .dac_code  (dac_code),
        .done      (done),
        .result    (result)
    );

    assign chan_sel = ctrl.chan;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input seq_state_t     state,
    input logic           run,
    input logic           pdown,
    input logic           sample_en,
    input logic           analog_en,
    input logic [RES-1:0] dac_code,
    input logic [RES-1:0] data_q,
    input logic           eoc
);
    p_pdown_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |=> (!sample_en && !analog_en));

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sample_en);

    p_sample_dac_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (dac_code == '0));

    p_data_only_with_eoc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> eoc);

    p_eoc_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> ($past(state) == ST_SETTLE));

    p_trial_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE) |-> (dac_code != '0));
endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .run       (ctrl.run),
    .pdown     (ctrl.pdown),
    .sample_en (sample_en),
    .analog_en (analog_en),
    .dac_code  (dac_code),
    .data_q    (data_q),
    .eoc       (eoc)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_trig_n = 1'b1;
    logic       cmp_in;
    logic [2:0] chan_sel;
    logic       sample_en;
    logic       analog_en;
    logic [7:0] dac_code;
    logic       eoc;
    logic [7:0] vin [8];
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    adc_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_trig_n(ext_trig_n), .cmp_in(cmp_in),
        .chan_sel(chan_sel), .sample_en(sample_en), .analog_en(analog_en),
        .dac_code(dac_code), .eoc(eoc)
    );

    // analog front end model
    assign cmp_in = (vin[chan_sel] >= dac_code);

    // control bit helpers
    localparam logic [7:0] B_FAST = 8'h08, B_CONT = 8'h10, B_RUN = 8'h20,
                           B_TRIG = 8'h40, B_PD = 8'h80;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic reg_write(input logic [7:0] v);
        wr_en = 1'b1; addr = 1'b0; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 1'b0;
    endtask

    // counts edges until eoc seen, and sample_en cycles on the way
    task automatic wait_eoc(input int limit, output int edges, output int samp);
        edges = 0; samp = 0;
        for (int i = 0; i < limit; i++) begin
            if (sample_en) samp++;
            @(negedge clk);
            edges++;
            if (eoc) return;
        end
        edges = -1;
    endtask

    task automatic idle_watch(input int n, output int eocs, output int samps);
        eocs = 0; samps = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (eoc) eocs++;
            if (sample_en) samps++;
        end
    endtask

    initial begin
        logic [7:0] rv;
        int e, s, e2, s2;
        for (int k = 0; k < 8; k++) vin[k] = 8'(k * 31 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(eoc == 0 && sample_en == 0 && analog_en == 1 && chan_sel == 0, "R1 outputs", {eoc, sample_en, analog_en}, 1);
        reg_read(1'b0, rv); check(rv == 0, "R1 ctrl", rv, 0);
        reg_read(1'b1, rv); check(rv == 0, "R1 data", rv, 0);

        // R3 R5 R2 R6 slow single conversion timing
        vin[2] = 8'hA5;
        reg_write(B_RUN | 8'd2);
        wait_eoc(400, e, s);
        check(e == 139, "R3 slow latency", e, 139);
        check(s == 84, "R5 slow sample length", s, 84);
        reg_read(1'b0, rv); check(rv[5] == 0, "R6 run cleared", rv, 8'd2);
        check(eoc == 1, "R11 eoc before read", eoc, 1);
        reg_read(1'b1, rv); check(rv == 8'hA5, "R2 slow result", rv, 8'hA5);
        check(eoc == 0, "R11 eoc cleared by read", eoc, 0);
        idle_watch(300, e2, s2);
        check(e2 == 0 && s2 == 0, "R6 no restart", e2 + s2, 0);

        // R4 R5 fast timing
        vin[6] = 8'h3C;
        reg_write(B_RUN | B_FAST | 8'd6);
        wait_eoc(400, e, s);
        check(e == 79, "R4 fast latency", e, 79);
        check(s == 48, "R5 fast sample length", s, 48);
        reg_read(1'b1, rv); check(rv == 8'h3C, "R2 fast result", rv, 8'h3C);

        // R2 R12 exhaustive sweep of levels, channels rotating
        for (int v = 0; v < 256; v++) begin
            int ch = v % 8;
            vin[ch] = 8'(v);
            reg_write(B_RUN | B_FAST | 8'(ch));
            if (chan_sel != 3'(ch)) check(0, "R12 chan_sel", chan_sel, ch);
            wait_eoc(200, e, s);
            reg_read(1'b1, rv);
            if (rv != 8'(v) || e != 79) check(0, "R2 sweep", rv, v);
        end
        check(1, "R2 sweep done", 0, 0);

        // R7 continuous fast: period 78
        vin[1] = 8'h77;
        reg_write(B_RUN | B_FAST | B_CONT | 8'd1);
        wait_eoc(400, e, s);
        reg_read(1'b1, rv); check(rv == 8'h77, "R7 cont result", rv, 8'h77);
        wait_eoc(400, e, s);
        check(e + 1 == 78, "R7 fast period", e + 1, 78);
        vin[1] = 8'h12;
        reg_read(1'b1, rv);
        wait_eoc(400, e, s);
        check(e + 1 == 78, "R7 fast period 2", e + 1, 78);
        reg_read(1'b1, rv); check(rv == 8'h12, "R7 tracks input", rv, 8'h12);
        // R7 continuous slow
        reg_write(B_RUN | B_CONT | 8'd1);
        wait_eoc(400, e, s);
        reg_read(1'b1, rv);
        wait_eoc(400, e, s);
        check(e + 1 == 138, "R7 slow period", e + 1, 138);
        reg_read(1'b1, rv);
        reg_write(8'd1);
        idle_watch(10, e2, s2);
        if (eoc) reg_read(1'b1, rv);
        reg_read(1'b1, rv);
        reg_read(1'b1, rv);

        // R9 abort in the middle of decisions
        vin[3] = 8'hEE;
        reg_write(B_RUN | 8'd3);
        repeat (100) @(negedge clk);
        reg_write(8'd3);
        idle_watch(300, e2, s2);
        check(e2 == 0, "R9 no eoc after abort", e2, 0);
        check(s2 == 0, "R9 idle after abort", s2, 0);
        reg_read(1'b1, rv); check(rv == 8'h12, "R9 data unchanged", rv, 8'h12);

        // R8 trigger enabled
        vin[4] = 8'h5A;
        reg_write(B_TRIG | B_FAST | 8'd4);
        ext_trig_n = 1'b0;
        wait_eoc(300, e, s);
        check(e > 0, "R8 trigger starts", e, 1);
        reg_read(1'b1, rv); check(rv == 8'h5A, "R8 trigger result", rv, 8'h5A);
        ext_trig_n = 1'b1;
        repeat (5) @(negedge clk);
        // R8 trigger disabled
        reg_write(B_FAST | 8'd4);
        ext_trig_n = 1'b0;
        idle_watch(300, e2, s2);
        check(e2 == 0 && s2 == 0, "R8 trigger ignored", e2 + s2, 0);
        ext_trig_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 power down blocks run and trigger
        reg_write(B_PD | B_RUN | B_TRIG | B_FAST);
        @(negedge clk);
        check(analog_en == 0, "R10 analog off", analog_en, 0);
        ext_trig_n = 1'b0;
        idle_watch(200, e2, s2);
        check(e2 == 0 && s2 == 0 && analog_en == 0, "R10 quiet", e2 + s2, 0);
        ext_trig_n = 1'b1;
        reg_write(8'd0);
        @(negedge clk);
        check(analog_en == 1 && sample_en == 0, "R10 wake idle", analog_en, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule